// File: doc/BRIEF.md
# Partitioned Page-Erasable Memory Controller

This block models a byte-wide non-volatile store and the command logic in front of it. The store has two independent partitions. The main partition holds 4096 bytes for program code and coefficients. The small partition holds 128 bytes for identification and calibration data. Every command names a partition and carries a 16-bit address. Each partition decodes only the low address bits it needs and ignores the rest.

Four commands are accepted: read a byte, program a byte, erase one 64-byte page, and erase a whole partition. Programming can only clear bits, so the stored value becomes the old value ANDed with the supplied data. An erase sets bytes back to 0xFF. It holds a busy flag high for a fixed, parameterised number of cycles, and the controller drops every command it is offered during that time. No command aimed at one partition ever alters a byte of the other.

Top module: `pmem_ctrl`

## Requirements
- R1: After reset every byte of both partitions reads 0xFF, and busy and rd_valid are low.
- R2: A read (cmd_op = 0) accepted on a clock edge sets rd_valid high after the next edge, with rd_data holding the addressed byte; rd_valid is low in every cycle that does not follow an accepted read.
- R3: A byte program (cmd_op = 1) replaces the addressed byte with the old value ANDed with cmd_data, so bits can only go from 1 to 0.
- R4: For partition 0 (cmd_part = 0) the byte index is cmd_addr[11:0]; bits 15..12 have no effect.
- R5: For partition 1 (cmd_part = 1) the byte index is cmd_addr[6:0]; bits 15..7 have no effect.
- R6: A page erase (cmd_op = 2) sets the 64 bytes of page cmd_addr[11:6] (partition 0) or page cmd_addr[6] (partition 1) to 0xFF. Bits 5..0 select nothing, and no other page changes.
- R7: An all-erase (cmd_op = 3) sets every byte of the selected partition to 0xFF.
- R8: No read, program or erase on one partition changes any byte of the other partition.
- R9: An accepted erase raises busy on the following edge. Busy then stays high for exactly ERASE_CYCLES cycles, and the erased bytes read 0xFF once it falls.
- R10: Any command offered while busy is high is ignored: a read gives no rd_valid, and a program leaves the byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; blanks both partitions to 0xFF |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 2 | 0 read, 1 program, 2 page erase, 3 all-erase |
| cmd_part | input | 1 | Partition select: 0 main (4096 B), 1 small (128 B) |
| cmd_addr | input | 16 | Byte address; only the partition's low bits are decoded |
| cmd_data | input | 8 | Data to program (AND-merged) |
| rd_data | output | 8 | Byte returned by the last accepted read |
| rd_valid | output | 1 | rd_data is fresh this cycle |
| busy | output | 1 | An erase is in progress; commands are dropped |

## Verification
Two events can land in the same cycle: an erase finishing its last busy cycle, and a new command arriving. The bench keeps offering commands, alternating reads and programs aimed at the other partition, on every cycle while busy is high, up to and including the last one. It then checks that no read returned rd_valid, and a full dump later shows that the targeted byte kept its value. It also checks that busy was high for exactly the configured count, and that the erased page reads 0xFF on the first read after busy falls.

// File: rtl/pmem_ctrl.sv
module pmem_ctrl #(
  parameter int P0_AW        = 12,
  parameter int P1_AW        = 7,
  parameter int PAGE_AW      = 6,
  parameter int ERASE_CYCLES = 8,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_part,
  input  logic [15:0]   cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy
);
  localparam int P0_BYTES = 1 << P0_AW;
  localparam int P1_BYTES = 1 << P1_AW;
  localparam int PGW      = P0_AW - PAGE_AW;
  localparam int CW       = $clog2(ERASE_CYCLES + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_PROG = 2'd1;

  logic [DW-1:0]  mem0 [P0_BYTES];
  logic [DW-1:0]  mem1 [P1_BYTES];
  logic [CW-1:0]  cnt;
  logic           er_part, er_all;
  logic [PGW-1:0] er_page;

  wire              accept = cmd_valid && !busy;
  wire [P0_AW-1:0]  a0     = cmd_addr[P0_AW-1:0];
  wire [P1_AW-1:0]  a1     = cmd_addr[P1_AW-1:0];
  wire [PGW-1:0]    pg0    = a0[P0_AW-1:PAGE_AW];
  wire [PGW-1:0]    pg1    = PGW'(a1 >> PAGE_AW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < P0_BYTES; i++) mem0[i] <= '1;
      for (int i = 0; i < P1_BYTES; i++) mem1[i] <= '1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      er_part  <= 1'b0;
      er_all   <= 1'b0;
      er_page  <= '0;
    end else begin
      rd_valid <= accept && cmd_op == OP_RD;
      if (accept && cmd_op == OP_RD)
        rd_data <= cmd_part ? mem1[a1] : mem0[a0];
      if (accept && cmd_op == OP_PROG) begin
        if (cmd_part) mem1[a1] <= mem1[a1] & cmd_data;
        else          mem0[a0] <= mem0[a0] & cmd_data;
      end
      if (accept && cmd_op[1]) begin
        busy    <= 1'b1;
        cnt     <= CW'(ERASE_CYCLES - 1);
        er_part <= cmd_part;
        er_all  <= cmd_op[0];
        er_page <= cmd_part ? pg1 : pg0;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          for (int i = 0; i < P0_BYTES; i++)
            if (!er_part && (er_all || PGW'(i >> PAGE_AW) == er_page)) mem0[i] <= '1;
          for (int i = 0; i < P1_BYTES; i++)
            if (er_part && (er_all || PGW'(i >> PAGE_AW) == er_page)) mem1[i] <= '1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pmem_ctrl_chk.sv
module pmem_ctrl_chk #(
  parameter int ERASE_CYCLES = 8,
  parameter int DW           = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          cmd_part,
  input logic [15:0]   cmd_addr,
  input logic [DW-1:0] cmd_data,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          busy
);
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && cmd_op == 2'd0));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_op[1]));

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == ERASE_CYCLES);

  p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < ERASE_CYCLES);

  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !rd_valid);

  p_no_read_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);
endmodule

bind pmem_ctrl pmem_ctrl_chk #(.ERASE_CYCLES(ERASE_CYCLES), .DW(DW)) u_chk (.*);

// File: tb/pmem_ctrl_tb.sv
module pmem_ctrl_tb;
  localparam int E = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        cmd_part = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        busy;

  logic [7:0] ref0 [4096];
  logic [7:0] ref1 [128];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmem_ctrl #(.ERASE_CYCLES(E)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_part(cmd_part), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic part, logic [15:0] addr, logic [7:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_part = part; cmd_addr = addr; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(string req, logic part, logic [15:0] addr, logic [7:0] exp);
    issue(2'd0, part, addr, 8'h00);
    check({req, " rd_valid"}, int'(rd_valid), 1);
    check(req, int'(rd_data), int'(exp));
  endtask

  task automatic dump(string req, int salt);
    for (int i = 0; i < 4096; i++)
      read_chk({req, " R4 R8 p0"}, 1'b0, {4'(i * 5 + salt), 12'(i)}, ref0[i]);
    for (int i = 0; i < 128; i++)
      read_chk({req, " R5 R8 p1"}, 1'b1, {9'(i * 3 + salt), 7'(i)}, ref1[i]);
  endtask

  task automatic erase_run(string req, logic [1:0] op, logic part, logic [15:0] addr, bit poke);
    int n = 0;
    issue(op, part, addr, 8'h00);
    while (busy) begin
      n++;
      if (poke) begin
        if (n > 1) check("R10 no rd_valid while busy", int'(rd_valid), 0);
        cmd_valid = 1'b1; cmd_part = 1'b1; cmd_addr = 16'h0005; cmd_data = 8'h00;
        cmd_op = n[0] ? 2'd0 : 2'd1;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    if (poke) check("R10 no rd_valid after last busy", int'(rd_valid), 0);
    check({req, " R9 busy length"}, n, E);
    for (int i = 0; i < 4096; i++)
      if (!part && (op[0] || (i >> 6) == int'(addr[11:6]))) ref0[i] = 8'hFF;
    for (int i = 0; i < 128; i++)
      if (part && (op[0] || (i >> 6) == int'(addr[6]))) ref1[i] = 8'hFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) ref0[i] = 8'hFF;
    for (int i = 0; i < 128; i++)  ref1[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 rd_valid after reset", int'(rd_valid), 0);
    check("R2 rd_valid idle", int'(rd_valid), 0);
    dump("R1 blank", 0);

    // R3: program every byte through aliased addresses
    for (int i = 0; i < 4096; i++) begin
      issue(2'd1, 1'b0, {4'(i), 12'(i)}, 8'(i * 7 + 3));
      check("R2 no rd_valid after program", int'(rd_valid), 0);
      ref0[i] = ref0[i] & 8'(i * 7 + 3);
    end
    for (int i = 0; i < 128; i++) begin
      issue(2'd1, 1'b1, {9'(i + 200), 7'(i)}, 8'(i) ^ 8'h5A);
      ref1[i] = ref1[i] & (8'(i) ^ 8'h5A);
    end
    dump("R3 first program", 1);

    // R3: second program can only clear more bits
    for (int i = 0; i < 4096; i += 3) begin
      issue(2'd1, 1'b0, 16'(i), 8'hF0 ^ 8'(i));
      ref0[i] = ref0[i] & (8'hF0 ^ 8'(i));
    end
    for (int i = 0; i < 128; i += 5) begin
      issue(2'd1, 1'b1, 16'(i), 8'hCC);
      ref1[i] = ref1[i] & 8'hCC;
    end
    dump("R3 second program", 2);

    // R6: page 5 of partition 0, offset and high bits set; R10 poke during it
    erase_run("R6 p0 page", 2'd2, 1'b0, 16'hF16A, 1);
    read_chk("R6 R9 first read after busy", 1'b0, 16'h0140, 8'hFF);
    dump("R6 R10 after p0 page erase", 3);

    // R6: page 1 of partition 1 with unrelated high bits
    erase_run("R6 p1 page", 2'd2, 1'b1, 16'hFFC3, 0);
    dump("R6 after p1 page erase", 4);

    // R7: all-erase partition 1 only
    erase_run("R7 p1 all", 2'd3, 1'b1, 16'h1234, 0);
    dump("R7 after p1 all-erase", 5);

    // R8: program p1 again, then all-erase p0
    for (int i = 0; i < 128; i++) begin
      issue(2'd1, 1'b1, 16'(i), 8'(i * 9));
      ref1[i] = ref1[i] & 8'(i * 9);
    end
    erase_run("R7 p0 all", 2'd3, 1'b0, 16'h0000, 0);
    dump("R7 R8 after p0 all-erase", 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule